// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a parallel NOR flash model and turns captured host writes into operation requests. Each clock it may accept one write (an address and the low data byte). It walks the keyed unlock grammar: a data byte of AA at 5555, then 55 at 2AAA, then a command byte. Longer forms add a second AA/55 pair and a final byte. When a sequence completes, it raises a one-clock request that carries an operation code, the address and data of the final write, and the state of the external lockout-override input.

Besides the keyed forms, three single-write commands are decoded from the idle state: suspend an erase, resume an erase for a plane, and leave identification mode. A bypass mode can be entered with a six-write sequence. In that mode every accepted write becomes a program request, and the mode is left only through reset. The decoder also keeps an identification-mode flag and an erase-suspended flag. It ignores every write while the external busy input reports an embedded program.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, reqValid is 0, reqOp is 0, reqAddr and reqData are 0, and bypassMode, idMode and eraseSuspended are all 0.
- R2: The writes AA@5555, 55@2AAA and A0@5555, followed by any write, produce a program request (reqOp=1) carrying that fourth write's address and data. reqValid is high for exactly the one clock after the fourth write is accepted.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555 and 55@2AAA, followed by 10@5555, produce a chip-erase request (reqOp=2).
- R4: The same five-write prefix followed by data 30 at any address produces a sector-erase request (reqOp=3) whose reqAddr is that address.
- R5: The same prefix followed by data 40 at any address produces a sector-lockout request (reqOp=4) for that address.
- R6: The same prefix followed by A0@5555 sets bypassMode and produces no request. While bypassMode is 1, every accepted write produces a program request (reqOp=1), including the bytes B0, 30, 10 and AA. bypassMode clears only on reset.
- R7: AA@5555, 55@2AAA, 90@5555 produces reqOp=5 and sets idMode. AA@5555, 55@2AAA, F0@5555, or a single F0 at any address from idle, produces reqOp=6 and clears idMode.
- R8: From idle, a single B0 at any address produces reqOp=7 and sets eraseSuspended. A single 30 produces reqOp=8 and clears eraseSuspended; its reqAddr carries the plane in its top two bits.
- R9: A write presented while busyIn is 1 produces no request and does not advance, reset or otherwise change the sequence state or any mode flag.
- R10: While eraseSuspended is 1, a completed chip-erase or sector-erase sequence produces no request.
- R11: A write that does not match the expected step of a sequence returns the decoder to idle and produces no request, even when its data byte is a single-write command code.
- R12: Key steps compare only address bits 15..0; higher address bits are ignored.
- R13: Every request latches lockOverride into reqOverride. reqOp, reqAddr, reqData and reqOverride hold their values until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | A captured bus write is present this cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Low data byte of the write |
| busyIn | input | 1 | Embedded program in progress; writes are ignored |
| lockOverride | input | 1 | Lockout override level, latched with each request |
| reqValid | output | 1 | One-clock request pulse |
| reqOp | output | 4 | Operation code of the last request |
| reqAddr | output | ADDR_W | Address of the last request |
| reqData | output | 8 | Data of the last request |
| reqOverride | output | 1 | Override level latched with the last request |
| bypassMode | output | 1 | Single-write program mode active |
| idMode | output | 1 | Identification mode active |
| eraseSuspended | output | 1 | Erase suspend in effect |

## Verification
Four properties are checked on every cycle:
- a busy write leaves the sequence state unchanged;
- bypass mode never drops outside reset;
- every request raised in bypass mode is a program;
- no erase request is raised while an erase is suspended.

Each request pulse is also checked to carry a real operation code. The order-dependent grammar is shown only by the bench scenarios. These cover the full keyed sequences, mismatches partway through, a busy write in the middle of a sequence, keys with upper address bits set, and the sticky bypass mode. In each scenario the bench model is compared with every output on every clock.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE         = 4'd0,
    OP_PROGRAM      = 4'd1,
    OP_CHIP_ERASE   = 4'd2,
    OP_SECTOR_ERASE = 4'd3,
    OP_LOCKOUT      = 4'd4,
    OP_ID_ENTER     = 4'd5,
    OP_ID_EXIT      = 4'd6,
    OP_SUSPEND      = 4'd7,
    OP_RESUME       = 4'd8
  } cmdOp_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PGM, ST_EXT3, ST_EXT4, ST_EXT5
  } seqState_t;

  typedef struct packed {
    logic   fire;
    cmdOp_t op;
  } ctrlStrobe_t;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  CODE_PGM   = 8'hA0;
  localparam logic [7:0]  CODE_EXT   = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;
  localparam logic [7:0]  CODE_LOCK  = 8'h40;
  localparam logic [7:0]  CODE_IDIN  = 8'h90;
  localparam logic [7:0]  CODE_IDOUT = 8'hF0;
  localparam logic [7:0]  CODE_SUSP  = 8'hB0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busyIn,
  output ctrlStrobe_t       strobe,
  output logic              bypassMode,
  output logic              idMode,
  output logic              eraseSuspended
);

  localparam int KEY_W = 16;

  seqState_t state, nextState;
  logic nextBypass, nextId, nextSusp;
  logic accept, atKeyA, atKeyB;
  logic [KEY_W-1:0] keyAddr;

  assign keyAddr = wrAddr[KEY_W-1:0];
  assign accept  = wrValid && !busyIn;
  assign atKeyA  = (keyAddr == KEY_ADDR_A);
  assign atKeyB  = (keyAddr == KEY_ADDR_B);

  always_comb begin
    nextState   = state;
    nextBypass  = bypassMode;
    nextId      = idMode;
    nextSusp    = eraseSuspended;
    strobe.fire = 1'b0;
    strobe.op   = OP_NONE;
    if (accept) begin
      if (bypassMode) begin
        strobe.fire = 1'b1;
        strobe.op   = OP_PROGRAM;
      end else begin
        nextState = ST_IDLE;
        unique case (state)
          ST_IDLE: begin
            if (atKeyA && wrData == KEY_DATA_A) begin
              nextState = ST_KEY1;
            end else if (wrData == CODE_SUSP) begin
              strobe.fire = 1'b1;
              strobe.op   = OP_SUSPEND;
              nextSusp    = 1'b1;
            end else if (wrData == CODE_SECT) begin
              strobe.fire = 1'b1;
              strobe.op   = OP_RESUME;
              nextSusp    = 1'b0;
            end else if (wrData == CODE_IDOUT) begin
              strobe.fire = 1'b1;
              strobe.op   = OP_ID_EXIT;
              nextId      = 1'b0;
            end
          end
          ST_KEY1: if (atKeyB && wrData == KEY_DATA_B) nextState = ST_KEY2;
          ST_KEY2: begin
            if (atKeyA) begin
              if (wrData == CODE_PGM) nextState = ST_PGM;
              else if (wrData == CODE_EXT) nextState = ST_EXT3;
              else if (wrData == CODE_IDIN) begin
                strobe.fire = 1'b1;
                strobe.op   = OP_ID_ENTER;
                nextId      = 1'b1;
              end else if (wrData == CODE_IDOUT) begin
                strobe.fire = 1'b1;
                strobe.op   = OP_ID_EXIT;
                nextId      = 1'b0;
              end
            end
          end
          ST_PGM: begin
            strobe.fire = 1'b1;
            strobe.op   = OP_PROGRAM;
          end
          ST_EXT3: if (atKeyA && wrData == KEY_DATA_A) nextState = ST_EXT4;
          ST_EXT4: if (atKeyB && wrData == KEY_DATA_B) nextState = ST_EXT5;
          ST_EXT5: begin
            if (atKeyA && wrData == CODE_CHIP && !eraseSuspended) begin
              strobe.fire = 1'b1;
              strobe.op   = OP_CHIP_ERASE;
            end else if (wrData == CODE_SECT && !eraseSuspended) begin
              strobe.fire = 1'b1;
              strobe.op   = OP_SECTOR_ERASE;
            end else if (wrData == CODE_LOCK) begin
              strobe.fire = 1'b1;
              strobe.op   = OP_LOCKOUT;
            end else if (atKeyA && wrData == CODE_PGM) begin
              nextBypass = 1'b1;
            end
          end
          default: nextState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      bypassMode     <= 1'b0;
      idMode         <= 1'b0;
      eraseSuspended <= 1'b0;
    end else begin
      state          <= nextState;
      bypassMode     <= nextBypass;
      idMode         <= nextId;
      eraseSuspended <= nextSusp;
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && busyIn) |=> $stable(state));

  // R6
  bypass_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(bypassMode));

  // R6
  bypass_program_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bypassMode && strobe.fire) |-> (strobe.op == OP_PROGRAM));

  // R10
  no_erase_suspended_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eraseSuspended && strobe.fire) |->
      (strobe.op != OP_CHIP_ERASE && strobe.op != OP_SECTOR_ERASE));

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              lockOverride,
  output logic              reqValid,
  output logic [3:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic              reqOverride
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid    <= 1'b0;
      reqOp       <= '0;
      reqAddr     <= '0;
      reqData     <= '0;
      reqOverride <= 1'b0;
    end else begin
      reqValid <= strobe.fire;
      if (strobe.fire) begin
        reqOp       <= strobe.op;
        reqAddr     <= wrAddr;
        reqData     <= wrData;
        reqOverride <= lockOverride;
      end
    end
  end

  // R13
  req_op_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqOp != OP_NONE));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busyIn,
  input  logic              lockOverride,
  output logic              reqValid,
  output logic [3:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic              reqOverride,
  output logic              bypassMode,
  output logic              idMode,
  output logic              eraseSuspended
);

  ctrlStrobe_t strobe;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .busyIn(busyIn), .strobe(strobe),
    .bypassMode(bypassMode), .idMode(idMode), .eraseSuspended(eraseSuspended)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .lockOverride(lockOverride), .reqValid(reqValid),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .reqOverride(reqOverride)
  );

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic busyIn = 1'b0;
  logic lockOverride = 1'b0;
  logic reqValid, reqOverride, bypassMode, idMode, eraseSuspended;
  logic [3:0] reqOp;
  logic [AW-1:0] reqAddr;
  logic [7:0] reqData;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  int mStep;
  bit mBypass, mId, mSusp, eValid, eOvr;
  int eOp;
  logic [AW-1:0] eAddr;
  logic [7:0] eData;

  flash_cmd_decoder #(.ADDR_W(AW)) u_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .busyIn(busyIn), .lockOverride(lockOverride),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .reqOverride(reqOverride), .bypassMode(bypassMode), .idMode(idMode),
    .eraseSuspended(eraseSuspended)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic modelReset();
    mStep = 0; mBypass = 0; mId = 0; mSusp = 0;
    eValid = 0; eOp = 0; eAddr = '0; eData = '0; eOvr = 0;
  endtask

  task automatic emit(int op);
    eValid = 1; eOp = op; eAddr = wrAddr; eData = wrData; eOvr = lockOverride;
  endtask

  task automatic modelClock();
    logic [15:0] k;
    k = wrAddr[15:0];
    eValid = 0;
    if (wrValid && !busyIn) begin
      if (mBypass) emit(1);
      else begin
        int prev;
        prev = mStep;
        mStep = 0;
        if (prev == 0) begin
          if (k == 16'h5555 && wrData == 8'hAA) mStep = 1;
          else if (wrData == 8'hB0) begin emit(7); mSusp = 1; end
          else if (wrData == 8'h30) begin emit(8); mSusp = 0; end
          else if (wrData == 8'hF0) begin emit(6); mId = 0; end
        end else if (prev == 1) begin
          if (k == 16'h2AAA && wrData == 8'h55) mStep = 2;
        end else if (prev == 2) begin
          if (k == 16'h5555) begin
            if (wrData == 8'hA0) mStep = 3;
            else if (wrData == 8'h80) mStep = 4;
            else if (wrData == 8'h90) begin emit(5); mId = 1; end
            else if (wrData == 8'hF0) begin emit(6); mId = 0; end
          end
        end else if (prev == 3) emit(1);
        else if (prev == 4) begin
          if (k == 16'h5555 && wrData == 8'hAA) mStep = 5;
        end else if (prev == 5) begin
          if (k == 16'h2AAA && wrData == 8'h55) mStep = 6;
        end else begin
          if (wrData == 8'h10 && k == 16'h5555) begin if (!mSusp) emit(2); end
          else if (wrData == 8'h30) begin if (!mSusp) emit(3); end
          else if (wrData == 8'h40) emit(4);
          else if (wrData == 8'hA0 && k == 16'h5555) mBypass = 1;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    logic [38:0] got, exp;
    got = {reqValid, reqOp, reqAddr, reqData, reqOverride, bypassMode, idMode, eraseSuspended};
    exp = {eValid, eOp[3:0], eAddr, eData, eOvr, mBypass, mId, mSusp};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual v=%0b op=%0d a=%h d=%h ov=%0b byp=%0b id=%0b sus=%0b expected v=%0b op=%0d a=%h d=%h ov=%0b byp=%0b id=%0b sus=%0b",
        tag, reqValid, reqOp, reqAddr, reqData, reqOverride, bypassMode, idMode, eraseSuspended,
        eValid, eOp, eAddr, eData, eOvr, mBypass, mId, mSusp);
    end
  endtask

  task automatic step(bit v, logic [AW-1:0] a, logic [7:0] d, bit busy, string tag);
    wrValid = v; wrAddr = a; wrData = d; busyIn = busy;
    @(posedge clk);
    modelClock();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, string tag);
    step(1, a, d, 0, tag);
  endtask

  task automatic idle(string tag);
    step(0, '0, '0, 0, tag);
  endtask

  task automatic doReset();
    wrValid = 0; busyIn = 0;
    rstN = 0;
    modelReset();
    repeat (2) @(negedge clk);
    compare("R1");
    rstN = 1;
    idle("R1");
  endtask

  task automatic ext5(string tag);
    wr(20'h05555, 8'hAA, tag); wr(20'h02AAA, 8'h55, tag); wr(20'h05555, 8'h80, tag);
    wr(20'h05555, 8'hAA, tag); wr(20'h02AAA, 8'h55, tag);
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    doReset();

    // R2 program
    wr(20'h05555, 8'hAA, "R2"); wr(20'h02AAA, 8'h55, "R2"); wr(20'h05555, 8'hA0, "R2");
    wr(20'hABCDE, 8'h3C, "R2"); idle("R2"); idle("R13");

    // R12 upper bits ignored on keys
    wr(20'hF5555, 8'hAA, "R12"); wr(20'h32AAA, 8'h55, "R12"); wr(20'h85555, 8'hA0, "R12");
    wr(20'h01111, 8'h00, "R12"); idle("R12");

    // R3 chip erase, R4 sector erase, R5 lockout with override (R13)
    ext5("R3"); wr(20'h05555, 8'h10, "R3"); idle("R3");
    ext5("R4"); wr(20'h41234, 8'h30, "R4"); idle("R4");
    lockOverride = 1;
    ext5("R5"); wr(20'hF9ABC, 8'h40, "R5"); idle("R13");
    lockOverride = 0;

    // R7 identification enter and exits
    wr(20'h05555, 8'hAA, "R7"); wr(20'h02AAA, 8'h55, "R7"); wr(20'h05555, 8'h90, "R7");
    idle("R7"); wr(20'h12345, 8'hF0, "R7");
    wr(20'h05555, 8'hAA, "R7"); wr(20'h02AAA, 8'h55, "R7"); wr(20'h05555, 8'h90, "R7");
    wr(20'h05555, 8'hAA, "R7"); wr(20'h02AAA, 8'h55, "R7"); wr(20'h05555, 8'hF0, "R7");

    // R11 mismatches
    wr(20'h05555, 8'hAA, "R11"); wr(20'h02AAA, 8'hB0, "R11"); idle("R11");
    wr(20'h02AAA, 8'h55, "R11");
    wr(20'h05555, 8'hAA, "R11"); wr(20'h02AAA, 8'h55, "R11"); wr(20'h02AAA, 8'h30, "R11");
    ext5("R11"); wr(20'h05555, 8'h77, "R11"); wr(20'h00000, 8'h12, "R11");

    // R8 suspend, R10 erase refused, R8 resume with plane
    wr(20'h00777, 8'hB0, "R8"); idle("R8");
    ext5("R10"); wr(20'h41234, 8'h30, "R10"); idle("R10");
    ext5("R10"); wr(20'h05555, 8'h10, "R10"); idle("R10");
    ext5("R10"); wr(20'h05555, 8'h40, "R10");
    wr(20'hC0000, 8'h30, "R8"); idle("R8");

    // R9 busy writes ignored
    step(1, 20'h05555, 8'hAA, 1, "R9"); step(1, 20'h00000, 8'hB0, 1, "R9");
    wr(20'h02AAA, 8'h55, "R9"); wr(20'h05555, 8'hA0, "R9"); wr(20'h00042, 8'h99, "R9");
    wr(20'h05555, 8'hAA, "R9"); wr(20'h02AAA, 8'h55, "R9");
    step(1, 20'h00001, 8'h13, 1, "R9");
    wr(20'h05555, 8'hA0, "R9"); step(1, 20'h00002, 8'h14, 1, "R9");
    wr(20'h00003, 8'h15, "R9"); idle("R9");

    // R6 bypass
    ext5("R6"); wr(20'h05555, 8'hA0, "R6"); idle("R6");
    wr(20'h00100, 8'hB0, "R6"); wr(20'h80000, 8'h30, "R6"); wr(20'h05555, 8'h10, "R6");
    wr(20'h05555, 8'hAA, "R6"); wr(20'h02AAA, 8'h55, "R6"); idle("R6");
    step(1, 20'h00200, 8'h66, 1, "R6"); idle("R6");
    doReset();
    wr(20'h00300, 8'h88, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule